// File: doc/BRIEF.md
# Multi-Block Host Transfer Address Sequencer

This block produces the buffer-RAM word addresses for a data-in transfer to a host. Each handshake on the address stream stands for one word taken by the host. Two address modes exist. In block-offset mode the address is a block number times a fixed block size plus an offset. The offset wraps to zero at the block boundary. In linear mode a free-running address counter is used instead, and it wraps at the end of the RAM.

A transfer is split into one or more blocks. Each block carries a programmed word count. When the last word of a block that is not the final one is taken, the block handles its own bookkeeping. It reloads the word count and the starting offset, moves to the next block number (modulo the number of RAM blocks) and uses up one of the remaining blocks. No processor work is needed between blocks. A processor can append blocks while the transfer runs. The end-of-transfer flag is raised only after the final word of the final block. Dropping the enable input aborts the transfer at once.

The address output is a valid/ready stream. `addr_valid` stays high for the whole transfer. A word is consumed only in a cycle where `addr_valid`, `addr_ready` and `xfer_en` are all high. While `addr_ready` is low, `addr` holds its value. The configuration inputs are sampled only on an accepted start. They must lie in range: `cfg_block` below NUM_BLKS, `cfg_offset` below BLK_WORDS, and `cfg_start_addr` below BLK_WORDS*NUM_BLKS.

Top module: `mbt_addr_seq`

## Requirements
- R1: After reset, addr_valid, xfer_end, blk_flag and blk_irq are all 0.
- R2: A start pulse is accepted only when xfer_en is 1 and no transfer is active. From the next cycle addr_valid is 1. The first address is cfg_start_addr when cfg_linear=1, and cfg_block*BLK_WORDS+cfg_offset when cfg_linear=0. A start pulse that is not accepted has no effect.
- R3: While addr_valid=1 and addr_ready=0, addr holds its value. Each accepted handshake advances the sequence by exactly one word in the next cycle.
- R4: In block-offset mode (cfg_linear=0) the offset steps by one per word inside a block. It wraps from BLK_WORDS-1 to 0, and the block number does not change.
- R5: In linear mode (cfg_linear=1) the address steps by one per word, also across block ends. It wraps from BLK_WORDS*NUM_BLKS-1 to 0.
- R6: Every block carries exactly cfg_wc_m1+1 words (a 12-bit count).
- R7: A transfer carries cfg_blk_m1+1 blocks (a 5-bit count, 0 means one block). At each non-final block end the offset reloads to cfg_offset and the block number steps by one, modulo NUM_BLKS.
- R8: In the cycle after the handshake of the final word of the final block, addr_valid goes to 0 and xfer_end goes to 1. xfer_end is never 1 while addr_valid is 1.
- R9: A blk_inc pulse while a transfer is active adds one block. This includes a pulse in the same cycle as the final word's handshake. The count saturates at 31.
- R10: At each non-final block end, blk_flag is set if blk_flag_en=1. blk_irq pulses for one cycle, in the next cycle, if both blk_flag_en and blk_irq_en are 1. blk_flag clears on end_ack or on an accepted start.
- R11: When xfer_en=0, addr_valid is 0 in the next cycle, no word is consumed and xfer_end does not set.
- R12: end_ack clears xfer_end in the next cycle, unless the same cycle also sets it, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_linear | input | 1 | 1 = linear mode, 0 = block-offset mode |
| cfg_start_addr | input | ADDR_W | Linear-mode first address |
| cfg_block | input | BN_W | First block number |
| cfg_offset | input | OFF_W | Starting offset inside each block |
| cfg_wc_m1 | input | WC_W | Words per block minus one |
| cfg_blk_m1 | input | BC_W | Blocks minus one |
| start | input | 1 | Begin a transfer |
| xfer_en | input | 1 | Transfer enable; 0 aborts |
| blk_inc | input | 1 | Append one block |
| end_ack | input | 1 | Clear end and block flags |
| blk_flag_en | input | 1 | Enable per-block flag |
| blk_irq_en | input | 1 | Enable per-block interrupt pulse |
| addr_valid | output | 1 | Address valid (transfer active) |
| addr_ready | input | 1 | Host takes the current word |
| addr | output | ADDR_W | Buffer-RAM word address |
| xfer_end | output | 1 | Transfer complete flag |
| blk_flag | output | 1 | Non-final block end seen |
| blk_irq | output | 1 | One-cycle block-end interrupt |

## Verification
The assertions take the configuration as in range, with block, offset and start address inside the RAM. They also take the enables as sampled in the cycle of the block-end handshake. The address range check relies on both. The bench draws block numbers from 0 to NUM_BLKS-1 and offsets from 0 to BLK_WORDS-1. It draws start addresses below BLK_WORDS*NUM_BLKS and steers some of them close to each wrap point. All stimulus changes only on the falling clock edge.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int WC_W = 12;
  localparam int BC_W = 5;
  typedef enum logic {
    MODE_OFFSET = 1'b0,
    MODE_LINEAR = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/mbt_wrap_ctr.sv
// Loadable up-counter that wraps to zero after LIMIT-1.
module mbt_wrap_ctr #(
  parameter int W     = 4,
  parameter int LIMIT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (step)  q <= (q == TOP) ? '0 : q + 1'b1;
  end
endmodule

// File: rtl/mbt_down_ctr.sv
// Loadable down-counter for the per-block word count.
module mbt_down_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (dec)   q <= q - 1'b1;
  end
endmodule

// File: rtl/mbt_blk_ctr.sv
// Remaining-block counter: saturating append, decrement at block end.
module mbt_blk_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] q
);
  logic [W-1:0] eff;

  always_comb begin
    eff = (inc && (q != '1)) ? q + 1'b1 : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= '0;
    else if (load)         q <= load_val;
    else if (dec)          q <= eff - 1'b1;
    else                   q <= eff;
  end
endmodule

// File: rtl/mbt_addr_seq.sv
module mbt_addr_seq #(
  parameter int BLK_WORDS = 1176,
  parameter int NUM_BLKS  = 8,
  parameter int WC_W      = mbt_pkg::WC_W,
  parameter int BC_W      = mbt_pkg::BC_W,
  parameter int OFF_W     = $clog2(BLK_WORDS),
  parameter int BN_W      = $clog2(NUM_BLKS),
  parameter int ADDR_W    = $clog2(BLK_WORDS * NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_linear,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [BN_W-1:0]   cfg_block,
  input  logic [OFF_W-1:0]  cfg_offset,
  input  logic [WC_W-1:0]   cfg_wc_m1,
  input  logic [BC_W-1:0]   cfg_blk_m1,
  input  logic              start,
  input  logic              xfer_en,
  input  logic              blk_inc,
  input  logic              end_ack,
  input  logic              blk_flag_en,
  input  logic              blk_irq_en,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              xfer_end,
  output logic              blk_flag,
  output logic              blk_irq
);
  import mbt_pkg::*;

  localparam int RAM_WORDS = BLK_WORDS * NUM_BLKS;

  logic              active_q, end_q, flag_q, irq_q;
  addr_mode_e        mode_q;
  logic [WC_W-1:0]   wc_rl_q, wc_q;
  logic [OFF_W-1:0]  off_rl_q, off_q;
  logic [BN_W-1:0]   bn_q;
  logic [ADDR_W-1:0] lin_q;
  logic [BC_W-1:0]   bc_q;

  logic accept_start, hs, inc_acc, word_last, last_blk, blk_end, xfer_done;
  logic reload;

  always_comb begin
    accept_start = start && xfer_en && !active_q;
    hs           = active_q && xfer_en && addr_ready;
    inc_acc      = blk_inc && active_q && xfer_en;
    word_last    = hs && (wc_q == '0);
    last_blk     = (bc_q == '0) && !inc_acc;
    blk_end      = word_last && !last_blk;
    xfer_done    = word_last && last_blk;
    reload       = accept_start || blk_end;
  end

  mbt_down_ctr #(.W(WC_W)) u_wc (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .load_val(accept_start ? cfg_wc_m1 : wc_rl_q),
    .dec(hs && !word_last), .q(wc_q)
  );

  mbt_wrap_ctr #(.W(OFF_W), .LIMIT(BLK_WORDS)) u_off (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .load_val(accept_start ? cfg_offset : off_rl_q),
    .step(hs && !word_last), .q(off_q)
  );

  mbt_wrap_ctr #(.W(ADDR_W), .LIMIT(RAM_WORDS)) u_lin (
    .clk(clk), .rst_n(rst_n), .load(accept_start),
    .load_val(cfg_start_addr), .step(hs), .q(lin_q)
  );

  mbt_wrap_ctr #(.W(BN_W), .LIMIT(NUM_BLKS)) u_bn (
    .clk(clk), .rst_n(rst_n), .load(accept_start),
    .load_val(cfg_block), .step(blk_end), .q(bn_q)
  );

  mbt_blk_ctr #(.W(BC_W)) u_bc (
    .clk(clk), .rst_n(rst_n), .load(accept_start),
    .load_val(cfg_blk_m1), .inc(inc_acc), .dec(blk_end), .q(bc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      end_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      mode_q   <= MODE_OFFSET;
      wc_rl_q  <= '0;
      off_rl_q <= '0;
    end else begin
      irq_q <= blk_end && blk_flag_en && blk_irq_en;

      if (!xfer_en)          active_q <= 1'b0;
      else if (accept_start) active_q <= 1'b1;
      else if (xfer_done)    active_q <= 1'b0;

      if (accept_start) begin
        mode_q   <= addr_mode_e'(cfg_linear);
        wc_rl_q  <= cfg_wc_m1;
        off_rl_q <= cfg_offset;
      end

      if (accept_start)      end_q <= 1'b0;
      else if (xfer_done)    end_q <= 1'b1;
      else if (end_ack)      end_q <= 1'b0;

      if (accept_start)                    flag_q <= 1'b0;
      else if (blk_end && blk_flag_en)     flag_q <= 1'b1;
      else if (end_ack)                    flag_q <= 1'b0;
    end
  end

  always_comb begin
    if (mode_q == MODE_LINEAR)
      addr = lin_q;
    else
      addr = ADDR_W'(bn_q) * ADDR_W'(BLK_WORDS) + ADDR_W'(off_q);
  end

  assign addr_valid = active_q;
  assign xfer_end   = end_q;
  assign blk_flag   = flag_q;
  assign blk_irq    = irq_q;
endmodule

// File: rtl/mbt_addr_seq_chk.sv
module mbt_addr_seq_chk #(
  parameter int ADDR_W    = 14,
  parameter int RAM_WORDS = 9408
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_en,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic              xfer_end,
  input logic              end_ack,
  input logic              blk_flag_en,
  input logic              blk_irq_en,
  input logic              blk_irq
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && xfer_en) |=> $stable(addr));

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (int'(addr) < RAM_WORDS));

  p_end_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_end) |-> $past(addr_valid && addr_ready && xfer_en));

  p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_end && addr_valid));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |-> $past(blk_flag_en && blk_irq_en));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> !addr_valid);

  p_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && end_ack) |=> !xfer_end);
endmodule

bind mbt_addr_seq mbt_addr_seq_chk #(
  .ADDR_W(ADDR_W), .RAM_WORDS(BLK_WORDS * NUM_BLKS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr(addr), .xfer_end(xfer_end),
  .end_ack(end_ack), .blk_flag_en(blk_flag_en), .blk_irq_en(blk_irq_en),
  .blk_irq(blk_irq)
);

// File: tb/mbt_addr_seq_tb.sv
module mbt_addr_seq_tb_top;
  localparam int BW  = 1176;
  localparam int NB  = 8;
  localparam int RAM = BW * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_linear = 1'b0;
  logic [13:0] cfg_start_addr = '0;
  logic [2:0]  cfg_block = '0;
  logic [10:0] cfg_offset = '0;
  logic [11:0] cfg_wc_m1 = '0;
  logic [4:0]  cfg_blk_m1 = '0;
  logic start = 1'b0, xfer_en = 1'b1, blk_inc = 1'b0, end_ack = 1'b0;
  logic blk_flag_en = 1'b0, blk_irq_en = 1'b0, addr_ready = 1'b0;
  logic addr_valid, xfer_end, blk_flag, blk_irq;
  logic [13:0] addr;

  always #5 clk = ~clk;

  mbt_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_linear(cfg_linear),
    .cfg_start_addr(cfg_start_addr), .cfg_block(cfg_block),
    .cfg_offset(cfg_offset), .cfg_wc_m1(cfg_wc_m1), .cfg_blk_m1(cfg_blk_m1),
    .start(start), .xfer_en(xfer_en), .blk_inc(blk_inc), .end_ack(end_ack),
    .blk_flag_en(blk_flag_en), .blk_irq_en(blk_irq_en),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .xfer_end(xfer_end), .blk_flag(blk_flag), .blk_irq(blk_irq)
  );

  int n_chk = 0, n_bad = 0;
  int m_active = 0, m_mode = 0, m_wc = 0, m_off = 0, m_bn = 0, m_lin = 0;
  int m_bc = 0, m_end = 0, m_flag = 0, m_irq = 0, m_wc_rl = 0, m_off_rl = 0;
  int n_hs = 0, prev_hold = 0, prev_addr = 0;

  function automatic int exp_addr();
    return (m_mode != 0) ? m_lin : m_bn * BW + m_off;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare outputs with the model, drive one cycle of inputs, advance model.
  task automatic cyc(input bit st, input bit rdy, input bit inc, input bit ack,
                     input bit en);
    int hs, inc_a, wl, lb, bend, done, acc, t;
    chk("R8 addr_valid", int'(addr_valid), m_active);
    chk("R8 xfer_end", int'(xfer_end), m_end);
    chk("R10 blk_flag", int'(blk_flag), m_flag);
    chk("R10 blk_irq", int'(blk_irq), m_irq);
    if (m_active != 0) begin
      chk(m_mode != 0 ? "R5 linear addr" : "R4 offset addr", int'(addr), exp_addr());
      if (prev_hold != 0) chk("R3 hold addr", int'(addr), prev_addr);
    end
    prev_hold = (m_active != 0 && !rdy && en) ? 1 : 0;
    prev_addr = int'(addr);
    start = st; addr_ready = rdy; blk_inc = inc; end_ack = ack; xfer_en = en;

    hs    = (m_active != 0 && en && rdy) ? 1 : 0;
    inc_a = (inc && m_active != 0 && en) ? 1 : 0;
    wl    = (hs != 0 && m_wc == 0) ? 1 : 0;
    lb    = (m_bc == 0 && inc_a == 0) ? 1 : 0;
    bend  = (wl != 0 && lb == 0) ? 1 : 0;
    done  = (wl != 0 && lb != 0) ? 1 : 0;
    acc   = (st && en && m_active == 0) ? 1 : 0;
    m_irq = (bend != 0 && blk_flag_en && blk_irq_en) ? 1 : 0;
    if (acc != 0) m_end = 0; else if (done != 0) m_end = 1; else if (ack) m_end = 0;
    if (acc != 0) m_flag = 0; else if (bend != 0 && blk_flag_en) m_flag = 1;
    else if (ack) m_flag = 0;
    if (hs != 0) n_hs++;
    if (acc != 0) begin
      m_mode = int'(cfg_linear); m_wc = int'(cfg_wc_m1); m_wc_rl = m_wc;
      m_off = int'(cfg_offset); m_off_rl = m_off; m_bn = int'(cfg_block);
      m_lin = int'(cfg_start_addr); m_bc = int'(cfg_blk_m1);
    end else begin
      t = m_bc;
      if (inc_a != 0 && t != 31) t++;
      if (bend != 0) begin
        m_wc = m_wc_rl; m_off = m_off_rl; m_bn = (m_bn + 1) % NB; m_bc = t - 1;
      end else begin
        m_bc = t;
        if (hs != 0 && wl == 0) begin
          m_wc--; m_off = (m_off == BW - 1) ? 0 : m_off + 1;
        end
      end
      if (hs != 0) m_lin = (m_lin == RAM - 1) ? 0 : m_lin + 1;
    end
    if (!en) m_active = 0; else if (acc != 0) m_active = 1; else if (done != 0) m_active = 0;
    @(negedge clk);
  endtask

  task automatic go(input bit lin, input int sa, input int blk, input int off,
                    input int wcm1, input int bcm1);
    cfg_linear = lin; cfg_start_addr = 14'(sa); cfg_block = 3'(blk);
    cfg_offset = 11'(off); cfg_wc_m1 = 12'(wcm1); cfg_blk_m1 = 5'(bcm1);
    n_hs = 0;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic drain(input int rdy_pct, input int inc_pct);
    for (int i = 0; i < 3000 && m_active != 0; i++)
      cyc(1'b0, ($urandom % 100) < rdy_pct, ($urandom % 100) < inc_pct, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", int'(addr_valid), 0);
    chk("R1 end at reset", int'(xfer_end), 0);
    chk("R1 flag at reset", int'(blk_flag), 0);
    chk("R1 irq at reset", int'(blk_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Offset mode: offset wrap inside block, two blocks, flag and irq.
    blk_flag_en = 1'b1; blk_irq_en = 1'b1;
    go(1'b0, 0, 2, BW - 2, 3, 1);
    chk("R2 first offset addr", int'(addr), 2 * BW + BW - 2);
    drain(100, 0);
    chk("R6 R7 words in 2x4 transfer", n_hs, 8);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R12 end cleared by ack", int'(xfer_end), 0);

    // Linear mode across the RAM end, random back-pressure.
    go(1'b1, RAM - 2, 0, 0, 2, 1);
    chk("R2 first linear addr", int'(addr), RAM - 2);
    drain(40, 0);
    chk("R6 R7 linear words", n_hs, 6);

    // Block-number wrap, flag only.
    blk_irq_en = 1'b0;
    go(1'b0, 0, NB - 1, 5, 1, 2);
    drain(70, 0);
    chk("R7 words over block wrap", n_hs, 6);

    // Append a block mid-transfer.
    go(1'b0, 0, 3, 0, 1, 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    drain(100, 0);
    chk("R9 appended block mid-transfer", n_hs, 4);

    // Append in the same cycle as the final handshake; ack there too.
    go(1'b0, 0, 1, 7, 0, 0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    drain(100, 0);
    chk("R9 appended block at last word", n_hs, 2);
    go(1'b1, 100, 0, 0, 0, 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R12 set wins over ack", int'(xfer_end), 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // Start while active is ignored.
    go(1'b0, 0, 4, 10, 3, 0);
    cfg_block = 3'd6; cfg_wc_m1 = 12'd50;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    drain(100, 0);
    chk("R2 restart ignored while active", n_hs, 4);

    // Abort, then a start under xfer_en low.
    go(1'b0, 0, 0, 0, 20, 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 valid low after abort", int'(addr_valid), 0);
    chk("R11 no end after abort", int'(xfer_end), 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 start ignored with enable low", int'(addr_valid), 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // Constrained random transfers.
    for (int k = 0; k < 60; k++) begin
      int sa, blk, off;
      blk_flag_en = 1'($urandom); blk_irq_en = 1'($urandom);
      sa  = ($urandom % 2) ? RAM - 1 - int'($urandom % 6) : int'($urandom % RAM);
      off = ($urandom % 2) ? BW - 1 - int'($urandom % 6) : int'($urandom % BW);
      blk = int'($urandom % NB);
      go(1'($urandom), sa, blk, off, int'($urandom % 10), int'($urandom % 4));
      drain(30 + int'($urandom % 71), 4);
      if ($urandom % 2) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule